// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block turns a 32-bit virtual address, tagged with a context number, into a 36-bit physical address. It reads a chain of 32-bit table words from memory. The walk starts with a context table whose base comes from a pointer input. The context number selects one word there. That word either maps the whole virtual space or points to a level-1 table. Level-1 and level-2 words may also end the walk with a leaf, which maps 16 MB or 256 KB. A level-3 leaf maps a 4 KB page. A pointer word keeps the next table's base in its upper 28 bits, shifted down by 4, so 32-bit words can reach a 36-bit physical space.

The block takes one request at a time. It issues one memory read per level and holds each read until the memory acknowledges it. When it finds a leaf, it sets the leaf's referenced flag, and on a write access also its modified flag. It writes the word back only when one of these flags actually changed. The response carries the physical address, the leaf's permission field and cacheable flag, the level at which the walk ended, and a fault code.

Top module: `table_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `reqReady` is 1 and `memReq` and `rspValid` are 0.
- R2: The context table word is read at byte address `{ctxPtr,8'h00} + 4*reqCtx`. Level-1, level-2 and level-3 words are read at the next table's base plus 4 times the index. The indices are vaddr[31:24], vaddr[23:18] and vaddr[17:12].
- R3: Bits 1:0 of each fetched word give its type: 0 invalid, 1 pointer, 2 leaf, 3 reserved. An invalid word ends the walk with fault code 1. A reserved word ends it with fault code 2. A pointer fetched at level 3 ends it with fault code 3. `rspLevel` reports the level of the word that ended the walk, with the context word as level 0.
- R4: A leaf at level 0, 1, 2 or 3 passes through virtual bits 31:0, 23:0, 17:0 or 11:0 unchanged. The physical bits above these come from leaf bits 31:8, placed as physical bits 35:12.
- R5: A pointer's next-table base is its bits 31:4 followed by eight zero bits. The context pointer input uses the same layout.
- R6: Exactly one read is issued per level visited. `memReq`, `memWe` and `memAddr` hold steady until `memAck`, and an acknowledge may arrive in the same cycle as the request.
- R7: A successful walk sets referenced (bit 5) in the leaf, and on a write access also modified (bit 6). The updated word is written back to the leaf's own address only if it differs from the fetched word.
- R8: The response gives permission = leaf bits 4:2 and cacheable = leaf bit 7, with fault code 0. `rspValid` is a single-cycle pulse, and `reqReady` is 1 only while no walk is in progress.
- R9: A walk that ends in a fault performs no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Translation request strobe |
| reqReady | output | 1 | Walker idle, request accepted this cycle |
| reqVaddr | input | 32 | Virtual address to translate |
| reqCtx | input | CTX_W | Context number |
| reqWrite | input | 1 | 1 for a write access |
| ctxPtr | input | 28 | Context table base, bits 35:8 of the physical address |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWe | output | 1 | 1 for a write-back, 0 for a table read |
| memAddr | output | 36 | Physical byte address of the table word |
| memWdata | output | 32 | Updated leaf word for a write-back |
| memAck | input | 1 | Memory acknowledge, may come in the cycle of the request |
| memRdata | input | 32 | Table word, valid with `memAck` on a read |
| rspValid | output | 1 | Single-cycle response strobe |
| rspPaddr | output | 36 | Translated physical address |
| rspPerm | output | 3 | Leaf permission field |
| rspCache | output | 1 | Leaf cacheable flag |
| rspLevel | output | 2 | Level at which the walk ended (0 = context) |
| rspFault | output | 2 | 0 none, 1 invalid, 2 reserved type, 3 pointer at level 3 |

## Verification
Two things can happen in the same cycle. First, the memory acknowledge can land in the same cycle a read is first raised. The decode of that word then has to pick the next level, the leaf capture or the fault in that cycle. Second, a single write-back has to set both the referenced and the modified flags at once. The memory model runs the walks with zero, one and two cycles of acknowledge latency. The scoreboard compares each response with values derived by hand from the table contents. After each walk the bench reads the leaf word back and counts the reads and writes, which shows whether both flags were merged into one write and whether a write-back was skipped when nothing changed.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int ENT_W  = 32;
  localparam int PA_W   = 36;
  localparam int VA_W   = 32;
  localparam int LVL_W  = 2;
  localparam int PTR_LO = 4;
  localparam int PPN_LO = 8;
  localparam int BASE_SHIFT = 8;
  localparam int LAST_LVL = 3;

  localparam logic [1:0] ET_INV = 2'd0;
  localparam logic [1:0] ET_PTD = 2'd1;
  localparam logic [1:0] ET_PTE = 2'd2;
  localparam logic [1:0] ET_RSV = 2'd3;

  localparam logic [1:0] FLT_NONE     = 2'd0;
  localparam logic [1:0] FLT_INVALID  = 2'd1;
  localparam logic [1:0] FLT_RESERVED = 2'd2;
  localparam logic [1:0] FLT_DEPTH    = 2'd3;

  localparam int REF_BIT   = 5;
  localparam int MOD_BIT   = 6;
  localparam int CACHE_BIT = 7;
  localparam int PERM_LO   = 2;
  localparam int PERM_W    = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WRBACK,
    ST_RESP
  } walk_state_t;

  typedef struct packed {
    logic capReq;
    logic descend;
    logic capLeaf;
    logic capFault;
  } walk_strobe_t;

  // number of virtual bits passed through when a leaf ends the walk at lvl
  function automatic int offsetBits(input logic [LVL_W-1:0] lvl);
    case (lvl)
      2'd0:    return 32;
      2'd1:    return 24;
      2'd2:    return 18;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         memAck,
  input  logic         entIsPtd,
  input  logic         entIsPte,
  input  logic         atLast,
  input  logic         needWb,
  output walk_strobe_t stb,
  output logic         reqReady,
  output logic         memReq,
  output logic         memWe,
  output logic         rspValid
);

  walk_state_t st, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt      = st;
    stb      = '0;
    reqReady = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    rspValid = 1'b0;
    unique case (st)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.capReq = 1'b1;
          nxt        = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          if (entIsPte) begin
            stb.capLeaf = 1'b1;
            nxt         = needWb ? ST_WRBACK : ST_RESP;
          end else if (entIsPtd && !atLast) begin
            stb.descend = 1'b1;
          end else begin
            stb.capFault = 1'b1;
            nxt          = ST_RESP;
          end
        end
      end
      ST_WRBACK: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) nxt = ST_RESP;
      end
      ST_RESP: begin
        rspValid = 1'b1;
        nxt      = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // R6
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWe));

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReq && !rspValid);

  // R9
  fault_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capFault |=> !memWe);

endmodule

// File: rtl/ptw_dpath.sv
module ptw_dpath
  import ptw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  walk_strobe_t         stb,
  input  logic [VA_W-1:0]      reqVaddr,
  input  logic [CTX_W-1:0]     reqCtx,
  input  logic                 reqWrite,
  input  logic [PA_W-BASE_SHIFT-1:0] ctxPtr,
  input  logic [ENT_W-1:0]     memRdata,
  output logic [PA_W-1:0]      memAddr,
  output logic [ENT_W-1:0]     memWdata,
  output logic                 entIsPtd,
  output logic                 entIsPte,
  output logic                 atLast,
  output logic                 needWb,
  output logic [PA_W-1:0]      rspPaddr,
  output logic [PERM_W-1:0]    rspPerm,
  output logic                 rspCache,
  output logic [LVL_W-1:0]     rspLevel,
  output logic [1:0]           rspFault
);

  localparam int IDX_W = (CTX_W > 8) ? CTX_W : 8;

  logic [VA_W-1:0]  vaReg;
  logic [CTX_W-1:0] ctxReg;
  logic             wrReg;
  logic [PA_W-1:0]  baseReg;
  logic [LVL_W-1:0] lvlReg;
  logic [ENT_W-1:0] leafReg;
  logic [1:0]       faultReg;

  logic [1:0]       entType;
  logic [ENT_W-1:0] updLeaf;
  logic [1:0]       fltCode;
  logic [IDX_W-1:0] idx;
  logic [PA_W-1:0]  lowMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg    <= '0;
      ctxReg   <= '0;
      wrReg    <= 1'b0;
      baseReg  <= '0;
      lvlReg   <= '0;
      leafReg  <= '0;
      faultReg <= FLT_NONE;
    end else begin
      if (stb.capReq) begin
        vaReg    <= reqVaddr;
        ctxReg   <= reqCtx;
        wrReg    <= reqWrite;
        baseReg  <= {ctxPtr, {BASE_SHIFT{1'b0}}};
        lvlReg   <= '0;
        leafReg  <= '0;
        faultReg <= FLT_NONE;
      end
      if (stb.descend) begin
        baseReg <= {memRdata[ENT_W-1:PTR_LO], {BASE_SHIFT{1'b0}}};
        lvlReg  <= lvlReg + 1'b1;
      end
      if (stb.capLeaf)  leafReg  <= updLeaf;
      if (stb.capFault) faultReg <= fltCode;
    end
  end

  // entry decode on the word arriving with the acknowledge
  always_comb begin
    entType  = memRdata[1:0];
    entIsPtd = (entType == ET_PTD);
    entIsPte = (entType == ET_PTE);
    atLast   = (lvlReg == LVL_W'(LAST_LVL));
    updLeaf  = memRdata;
    updLeaf[REF_BIT] = 1'b1;
    if (wrReg) updLeaf[MOD_BIT] = 1'b1;
    needWb = (updLeaf != memRdata);
    case (entType)
      ET_INV:  fltCode = FLT_INVALID;
      ET_RSV:  fltCode = FLT_RESERVED;
      default: fltCode = FLT_DEPTH;
    endcase
  end

  // table index selection per level
  always_comb begin
    idx = '0;
    case (lvlReg)
      2'd0:    idx = IDX_W'(ctxReg);
      2'd1:    idx = IDX_W'(vaReg[31:24]);
      2'd2:    idx = IDX_W'(vaReg[23:18]);
      default: idx = IDX_W'(vaReg[17:12]);
    endcase
    memAddr  = baseReg + (PA_W'(idx) << 2);
    memWdata = leafReg;
  end

  // physical address composition
  always_comb begin
    lowMask  = (PA_W'(1) << offsetBits(lvlReg)) - PA_W'(1);
    rspPaddr = ({leafReg[ENT_W-1:PPN_LO], 12'h000} & ~lowMask)
             | ({{(PA_W-VA_W){1'b0}}, vaReg} & lowMask);
    rspPerm  = leafReg[PERM_LO +: PERM_W];
    rspCache = leafReg[CACHE_BIT];
    rspLevel = lvlReg;
    rspFault = faultReg;
  end

  // R3
  desc_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.descend |-> !atLast);

  // R7
  leaf_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capLeaf |=> leafReg[REF_BIT] && (!wrReg || leafReg[MOD_BIT]));

endmodule

// File: rtl/table_walker.sv
module table_walker
  import ptw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [31:0]       reqVaddr,
  input  logic [CTX_W-1:0]  reqCtx,
  input  logic              reqWrite,
  input  logic [27:0]       ctxPtr,
  output logic              memReq,
  output logic              memWe,
  output logic [35:0]       memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  output logic              rspValid,
  output logic [35:0]       rspPaddr,
  output logic [2:0]        rspPerm,
  output logic              rspCache,
  output logic [1:0]        rspLevel,
  output logic [1:0]        rspFault
);

  walk_strobe_t stb;
  logic entIsPtd, entIsPte, atLast, needWb;

  ptw_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .memAck   (memAck),
    .entIsPtd (entIsPtd),
    .entIsPte (entIsPte),
    .atLast   (atLast),
    .needWb   (needWb),
    .stb      (stb),
    .reqReady (reqReady),
    .memReq   (memReq),
    .memWe    (memWe),
    .rspValid (rspValid)
  );

  ptw_dpath #(.CTX_W(CTX_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqVaddr (reqVaddr),
    .reqCtx   (reqCtx),
    .reqWrite (reqWrite),
    .ctxPtr   (ctxPtr),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .entIsPtd (entIsPtd),
    .entIsPte (entIsPte),
    .atLast   (atLast),
    .needWb   (needWb),
    .rspPaddr (rspPaddr),
    .rspPerm  (rspPerm),
    .rspCache (rspCache),
    .rspLevel (rspLevel),
    .rspFault (rspFault)
  );

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr));

  // R7
  wb_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> memWdata[REF_BIT] && (memWdata[1:0] == ET_PTE));

  // R3
  depth_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && (rspFault == FLT_DEPTH) |-> rspLevel == 2'd3);

endmodule

// File: tb/sim_table_walker.sv
module sim_table_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [7:0]  reqCtx = '0;
  logic        reqWrite = 1'b0;
  logic [27:0] ctxPtr = '0;
  logic        memReq, memWe, memAck;
  logic [35:0] memAddr;
  logic [31:0] memWdata, memRdata;
  logic        rspValid;
  logic [35:0] rspPaddr;
  logic [2:0]  rspPerm;
  logic        rspCache;
  logic [1:0]  rspLevel, rspFault;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  table_walker #(.CTX_W(8)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqCtx(reqCtx), .reqWrite(reqWrite), .ctxPtr(ctxPtr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .rspValid(rspValid),
    .rspPaddr(rspPaddr), .rspPerm(rspPerm), .rspCache(rspCache),
    .rspLevel(rspLevel), .rspFault(rspFault)
  );

  // memory model: 4 KB, programmable acknowledge latency
  logic [31:0] mem [0:1023];
  int latency = 0;
  int waitCnt = 0;
  int rdCount = 0;
  int wrCount = 0;

  assign memAck   = memReq && (waitCnt == latency);
  assign memRdata = mem[memAddr[11:2]];

  always @(posedge clk) begin
    if (memReq && !memAck) waitCnt <= waitCnt + 1;
    else                   waitCnt <= 0;
    if (memReq && memAck) begin
      if (memWe) begin
        mem[memAddr[11:2]] <= memWdata;
        wrCount <= wrCount + 1;
      end else begin
        rdCount <= rdCount + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [35:0] pa;
    logic [2:0]  perm;
    logic        cache;
    logic [1:0]  lvl;
    logic [1:0]  flt;
    string       tag;
  } exp_t;

  exp_t sb[$];

  // monitor
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (sb.size() == 0) begin
        check("R8 unexpected response", 36'd1, 36'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " R3 level"}, 36'(rspLevel), 36'(e.lvl));
        check({e.tag, " R3 fault"}, 36'(rspFault), 36'(e.flt));
        if (e.flt == 2'd0) begin
          check({e.tag, " R4 paddr"}, rspPaddr, e.pa);
          check({e.tag, " R8 perm"}, 36'(rspPerm), 36'(e.perm));
          check({e.tag, " R8 cache"}, 36'(rspCache), 36'(e.cache));
        end
      end
    end
  end

  // driver
  task automatic walk(input logic [31:0] va, input logic [7:0] ctx, input logic wr,
                      input logic [35:0] pa, input logic [2:0] perm, input logic cache,
                      input logic [1:0] lvl, input logic [1:0] flt, input string tag);
    exp_t e;
    e.pa = pa; e.perm = perm; e.cache = cache; e.lvl = lvl; e.flt = flt; e.tag = tag;
    sb.push_back(e);
    while (!reqReady) @(negedge clk);
    reqVaddr = va; reqCtx = ctx; reqWrite = wr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r0, w0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    mem[12'h000 >> 2] = 32'h0000_0041;   // ctx0 -> L1 at 0x400
    mem[12'h008 >> 2] = 32'h5000_0022;   // ctx2 leaf, whole space
    mem[12'h404 >> 2] = 32'h9010_008E;   // L1[1] leaf 16 MB
    mem[12'h408 >> 2] = 32'h0000_0081;   // L1[2] -> L2 at 0x800
    mem[12'h814 >> 2] = 32'h1234_0062;   // L2[5] leaf 256 KB, ref+mod set
    mem[12'h818 >> 2] = 32'h0000_0091;   // L2[6] -> L3 at 0x900
    mem[12'h81C >> 2] = 32'h0000_0003;   // L2[7] reserved
    mem[12'h90C >> 2] = 32'h00AB_C00A;   // L3[3] leaf 4 KB
    mem[12'h914 >> 2] = 32'h0000_0091;   // L3[5] pointer at last level
    mem[12'hC0C >> 2] = 32'h0000_0041;   // relocated ctx table, ctx3

    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 ready in reset", 36'(reqReady), 36'd1);
    check("R1 memReq in reset", 36'(memReq), 36'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rspValid after reset", 36'(rspValid), 36'd0);
    check("R1 memReq after reset", 36'(memReq), 36'd0);

    latency = 0;
    r0 = rdCount; w0 = wrCount;
    walk(32'h01AB_CDEF, 8'd0, 1'b0, 36'h9_01AB_CDEF, 3'd3, 1'b1, 2'd1, 2'd0, "L1 leaf read");
    check("R7 ref set", 36'(mem[12'h404 >> 2]), 36'h9010_00AE);
    check("R6 reads for level-1 leaf", 36'(rdCount - r0), 36'd2);
    check("R7 one write", 36'(wrCount - w0), 36'd1);

    w0 = wrCount;
    walk(32'h01AB_CDEF, 8'd0, 1'b1, 36'h9_01AB_CDEF, 3'd3, 1'b1, 2'd1, 2'd0, "L1 leaf write");
    check("R7 mod set", 36'(mem[12'h404 >> 2]), 36'h9010_00EE);
    check("R7 write on mod change", 36'(wrCount - w0), 36'd1);

    w0 = wrCount;
    walk(32'h01AB_CDEF, 8'd0, 1'b0, 36'h9_01AB_CDEF, 3'd3, 1'b1, 2'd1, 2'd0, "L1 leaf reread");
    check("R7 no write when unchanged", 36'(wrCount - w0), 36'd0);

    latency = 2;
    w0 = wrCount;
    walk(32'h0214_2345, 8'd0, 1'b1, 36'h1_2340_2345, 3'd0, 1'b0, 2'd2, 2'd0, "L2 leaf write");
    check("R7 flags already set no write", 36'(wrCount - w0), 36'd0);

    r0 = rdCount; w0 = wrCount;
    walk(32'h0218_3567, 8'd0, 1'b1, 36'h0_0ABC_0567, 3'd2, 1'b0, 2'd3, 2'd0, "L3 leaf write");
    check("R7 ref and mod in one write", 36'(mem[12'h90C >> 2]), 36'h00AB_C06A);
    check("R7 single write-back", 36'(wrCount - w0), 36'd1);
    check("R6 one read per level", 36'(rdCount - r0), 36'd4);

    latency = 1;
    w0 = wrCount;
    walk(32'h0218_4000, 8'd0, 1'b1, 36'h0, 3'd0, 1'b0, 2'd3, 2'd1, "L3 invalid");
    walk(32'h0218_5000, 8'd0, 1'b1, 36'h0, 3'd0, 1'b0, 2'd3, 2'd3, "L3 pointer");
    walk(32'h021C_0000, 8'd0, 1'b1, 36'h0, 3'd0, 1'b0, 2'd2, 2'd2, "L2 reserved");
    walk(32'h0300_0000, 8'd0, 1'b1, 36'h0, 3'd0, 1'b0, 2'd1, 2'd1, "L1 invalid");
    walk(32'h0100_0000, 8'd1, 1'b1, 36'h0, 3'd0, 1'b0, 2'd0, 2'd1, "ctx invalid");
    check("R9 no write on faults", 36'(wrCount - w0), 36'd0);

    latency = 0;
    walk(32'hDEAD_BEEF, 8'd2, 1'b0, 36'h5_DEAD_BEEF, 3'd0, 1'b0, 2'd0, 2'd0, "R4 ctx leaf");

    // R5 R2: relocated context table
    ctxPtr = 28'h000_000C;
    walk(32'h0100_0123, 8'd3, 1'b0, 36'h9_0100_0123, 3'd3, 1'b1, 2'd1, 2'd0, "R2 relocated ctx");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule